// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable-Full Flag

This block is a first-in first-out buffer whose write side and read side run on separate clocks. A write port accepts one word per write-clock edge while the buffer is not full. A read port presents the oldest stored word on its data output whenever the buffer is not empty, and it consumes that word on a read-clock edge. The read data is shown ahead, so no extra cycle is needed after the read request. Write and read words have the same width.

Besides the full and empty flags, the write side drives a programmable-full flag. This flag compares the number of stored words, as the write domain sees it, with a threshold fixed at build time. Every write is counted in that view at once. A read enters the view only after the read pointer has crossed into the write domain. As a result the flag can report the buffer as fuller than it really is, but never as emptier. A build parameter selects how the clocks relate. In independent mode, gray-coded pointers cross through two-flop synchronizers. In shared-source mode the pointers are compared directly, with no synchronizer stages.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted, and while `empty` is low, `rd_data` equals the oldest stored word.
- R2: A write requested while `full` is high is ignored: no stored word is overwritten, and a buffer filled with 2^ADDR_W words yields exactly that many reads.
- R3: A read requested while `empty` is high is ignored: the read position does not move, so the next word written is the next word read.
- R4: `full` is never low while 2^ADDR_W words are stored. After both sides have been idle long enough to synchronize, `full` is high exactly when 2^ADDR_W words are stored.
- R5: `empty` is never low while no word is stored. After an idle period, `empty` is high exactly when no word is stored.
- R6: `prog_full` is never low while the true stored count is at or above `PF_LEVEL`.
- R7: A write that brings the write-domain count to `PF_LEVEL` raises `prog_full` at that same write-clock edge, and `prog_full` never rises in a cycle without an accepted write.
- R8: After a read, `prog_full` stays high for at least the synchronizer delay. Once the write-domain view falls below `PF_LEVEL` it drops, so after an idle period `prog_full` is high exactly when the stored count is at or above `PF_LEVEL`.
- R9: With `CLK_MODE` = independent, a written word takes at least three read-clock edges to clear `empty`. With `CLK_MODE` = shared, both clocks come from one source, and `empty` clears at the second read edge after the write edge.
- R10: While either reset is low, and right after release, `empty` is 1, `full` is 0 and `prog_full` is 0.
- R11: `DATA_W` must be one of 4, 9, 18, 36 or 72, and `PF_LEVEL` must lie in 1 to 2^ADDR_W. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry, in the write-side view |
| prog_full | output | 1 | Write-side count at or above PF_LEVEL |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read request, consumes the shown word |
| rd_data | output | DATA_W | Oldest stored word, valid while empty is low |
| empty | output | 1 | No stored word, in the read-side view |

## Verification
The hardest case to reach from the ports is the gap in which a read has already freed an entry but the write side still holds `prog_full` high. That state lasts only a few write-clock edges. To reach it, the stimulus first fills the buffer to one word below the threshold and waits for both sides to settle. A single write then raises the flag. A single read follows, and the flag is sampled just after that read's clock edge, while the pointer is still crossing, and then again after the crossing has completed. Unrelated clock periods and random traffic at several write and read densities also drive the pessimistic flags through many phase alignments. Throughout, a queue-based model confirms that no flag ever understates the stored count.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    typedef enum logic {
        CLK_SHARED = 1'b0,
        CLK_INDEP  = 1'b1
    } clk_mode_e;

    function automatic bit width_ok(input int w);
        return (w == 4) || (w == 9) || (w == 18) || (w == 36) || (w == 72);
    endfunction

endpackage

// File: rtl/xclk_ptr_sync.sv
module xclk_ptr_sync
    import xclk_fifo_pkg::*;
#(
    parameter int        W    = 5,
    parameter clk_mode_e MODE = CLK_INDEP
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    timeunit 1ns;
    timeprecision 100ps;

    generate
        if (MODE == CLK_INDEP) begin : g_two_flop
            typedef struct packed {
                logic [W-1:0] meta;
                logic [W-1:0] held;
            } sync_t;

            sync_t s_d, s_q;

            always_comb begin
                s_d      = s_q;
                s_d.meta = src;
                s_d.held = s_q.meta;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '0;
                else        s_q <= s_d;
            end

            assign dst = s_q.held;
        end else begin : g_direct
            logic unused_sync;
            assign unused_sync = clk ^ rst_n;
            assign dst = src;
        end
    endgenerate

endmodule

// File: rtl/xclk_wr_ctrl.sv
module xclk_wr_ctrl #(
    parameter int ADDR_W   = 4,
    parameter int PF_LEVEL = 12
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic [ADDR_W:0]   wr_bin,
    output logic [ADDR_W:0]   wr_gray,
    output logic              wr_fire,
    output logic              full,
    output logic              prog_full
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P = ADDR_W + 1;

    typedef struct packed {
        logic [P-1:0] bin;
        logic [P-1:0] gray;
        logic         full;
        logic         pf;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [P-1:0] rd_bin_v;
    logic [P-1:0] level;
    logic [P-1:0] full_pat;

    function automatic logic [P-1:0] to_bin(input logic [P-1:0] g);
        logic [P-1:0] b;
        b[P-1] = g[P-1];
        for (int i = P - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        st_d     = st_q;
        wr_fire  = wr_en && !st_q.full;
        st_d.bin = st_q.bin + P'(wr_fire);
        st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
        rd_bin_v = to_bin(rd_gray_s);
        level    = st_d.bin - rd_bin_v;
        full_pat = {~rd_gray_s[P-1:P-2], rd_gray_s[P-3:0]};
        st_d.full = (st_d.gray == full_pat);
        st_d.pf   = (level >= P'(PF_LEVEL));
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign wr_bin    = st_q.bin;
    assign wr_gray   = st_q.gray;
    assign full      = st_q.full;
    assign prog_full = st_q.pf;

endmodule

// File: rtl/xclk_rd_ctrl.sv
module xclk_rd_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic            rd_clk,
    input  logic            rd_rst_n,
    input  logic            rd_en,
    input  logic [ADDR_W:0] wr_gray_s,
    output logic [ADDR_W:0] rd_bin,
    output logic [ADDR_W:0] rd_gray,
    output logic            empty
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P = ADDR_W + 1;

    typedef struct packed {
        logic [P-1:0] bin;
        logic [P-1:0] gray;
        logic         empty;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      rd_fire;

    always_comb begin
        st_d       = st_q;
        rd_fire    = rd_en && !st_q.empty;
        st_d.bin   = st_q.bin + P'(rd_fire);
        st_d.gray  = (st_d.bin >> 1) ^ st_d.bin;
        st_d.empty = (st_d.gray == wr_gray_s);
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_bin  = st_q.bin;
    assign rd_gray = st_q.gray;
    assign empty   = st_q.empty;

endmodule

// File: rtl/xclk_ram.sv
module xclk_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
    import xclk_fifo_pkg::*;
#(
    parameter int        DATA_W   = 9,
    parameter int        ADDR_W   = 4,
    parameter int        PF_LEVEL = 12,
    parameter clk_mode_e CLK_MODE = CLK_INDEP
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              prog_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    // R11: build-time legality of the parameters
    if (!width_ok(DATA_W)) begin : g_bad_width
        $error("xclk_fifo: DATA_W must be 4, 9, 18, 36 or 72");
    end
    if (PF_LEVEL < 1 || PF_LEVEL > DEPTH) begin : g_bad_level
        $error("xclk_fifo: PF_LEVEL must lie in 1..2**ADDR_W");
    end
    if (ADDR_W < 2) begin : g_bad_addr
        $error("xclk_fifo: ADDR_W must be at least 2");
    end

    logic [P-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [P-1:0] wr_gray_s, rd_gray_s;
    logic         wr_fire;

    xclk_wr_ctrl #(
        .ADDR_W  (ADDR_W),
        .PF_LEVEL(PF_LEVEL)
    ) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .rd_gray_s(rd_gray_s),
        .wr_bin   (wr_bin),
        .wr_gray  (wr_gray),
        .wr_fire  (wr_fire),
        .full     (full),
        .prog_full(prog_full)
    );

    xclk_rd_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_rd (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .wr_gray_s(wr_gray_s),
        .rd_bin   (rd_bin),
        .rd_gray  (rd_gray),
        .empty    (empty)
    );

    xclk_ptr_sync #(
        .W   (P),
        .MODE(CLK_MODE)
    ) u_rd2wr (
        .clk  (wr_clk),
        .rst_n(wr_rst_n),
        .src  (rd_gray),
        .dst  (rd_gray_s)
    );

    xclk_ptr_sync #(
        .W   (P),
        .MODE(CLK_MODE)
    ) u_wr2rd (
        .clk  (rd_clk),
        .rst_n(rd_rst_n),
        .src  (wr_gray),
        .dst  (wr_gray_s)
    );

    xclk_ram #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .wr_clk(wr_clk),
        .we    (wr_fire),
        .waddr (wr_bin[ADDR_W-1:0]),
        .wdata (wr_data),
        .raddr (rd_bin[ADDR_W-1:0]),
        .rdata (rd_data)
    );

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int ADDR_W   = 4,
    parameter int PF_LEVEL = 12
) (
    input logic            wr_clk,
    input logic            wr_rst_n,
    input logic            rd_clk,
    input logic            rd_rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            empty,
    input logic            prog_full,
    input logic [ADDR_W:0] wr_bin,
    input logic [ADDR_W:0] rd_bin
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P     = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [P-1:0] true_cnt;
    assign true_cnt = wr_bin - rd_bin;

    // R2
    wr_hold_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (wr_en && full) |=> $stable(wr_bin));

    // R3
    rd_hold_empty_chk: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (rd_en && empty) |=> $stable(rd_bin));

    // R4
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        true_cnt <= P'(DEPTH));

    // R5
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!wr_rst_n || !rd_rst_n)
        !empty |-> (wr_bin != rd_bin));

    // R6
    pf_pessimistic_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        (true_cnt >= P'(PF_LEVEL)) |-> prog_full);

    // R7
    pf_rise_cause_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n || !rd_rst_n)
        $rose(prog_full) |-> $past(wr_en && !full));

endmodule

bind xclk_fifo xclk_fifo_chk #(
    .ADDR_W  (ADDR_W),
    .PF_LEVEL(PF_LEVEL)
) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .full     (full),
    .empty    (empty),
    .prog_full(prog_full),
    .wr_bin   (wr_bin),
    .rd_bin   (rd_bin)
);

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW    = 9;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int PF    = 12;

    logic wr_clk = 1'b0;
    logic rd_clk = 1'b0;
    logic rst_n  = 1'b0;
    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, empty, prog_full;

    logic          c_wr_en = 1'b0, c_rd_en = 1'b0;
    logic [DW-1:0] c_wr_data = '0;
    logic [DW-1:0] c_rd_data;
    logic          c_full, c_empty, c_pf;

    xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .PF_LEVEL(PF),
                .CLK_MODE(xclk_fifo_pkg::CLK_INDEP)) uut (
        .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .prog_full(prog_full),
        .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty)
    );

    xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .PF_LEVEL(PF),
                .CLK_MODE(xclk_fifo_pkg::CLK_SHARED)) uut_shared (
        .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(c_wr_en), .wr_data(c_wr_data),
        .full(c_full), .prog_full(c_pf),
        .rd_clk(wr_clk), .rd_rst_n(rst_n), .rd_en(c_rd_en), .rd_data(c_rd_data),
        .empty(c_empty)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int wr_prob = 0, rd_prob = 0, wr_todo = 0, rd_todo = 0;
    int n_pops  = 0;
    bit wr_acc = 1'b0, rd_acc = 1'b0;
    bit finished = 1'b0;
    logic [DW-1:0] model_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Write driver and write-side model
    always @(negedge wr_clk) begin
        bit go;
        if (wr_acc) model_q.push_back(wr_data);
        if (rst_n) begin
            if (model_q.size() >= DEPTH) chk(full, "R4 full while all entries held", full, 1);
            if (model_q.size() >= PF) chk(prog_full, "R6 prog_full at or above level", prog_full, 1);
        end
        go = (wr_todo > 0) || (int'($urandom_range(99)) < wr_prob);
        wr_en   = go;
        wr_data = DW'($urandom);
        wr_acc  = go && !full && rst_n;
        if (wr_acc && wr_todo > 0) wr_todo--;
    end

    // Read driver, data ordering checks
    always @(negedge rd_clk) begin
        bit go;
        if (rd_acc) begin
            if (model_q.size() > 0) void'(model_q.pop_front());
            n_pops++;
        end
        if (rst_n && !empty) begin
            chk(model_q.size() > 0, "R5 empty low with nothing stored", model_q.size(), 1);
            if (model_q.size() > 0)
                chk(rd_data == model_q[0], "R1 head word", rd_data, model_q[0]);
        end
        go = (rd_todo > 0) || (int'($urandom_range(99)) < rd_prob);
        rd_en  = go;
        rd_acc = go && !empty && rst_n;
        if (rd_acc && rd_todo > 0) rd_todo--;
    end

    task automatic settle();
        wr_prob = 0;
        rd_prob = 0;
        wait (wr_todo == 0 && rd_todo == 0);
        repeat (12) @(negedge rd_clk);
        #1;
    endtask

    task automatic check_exact(input string tag);
        int n;
        n = model_q.size();
        chk(full == (n == DEPTH), {"R4 settled full ", tag}, full, n == DEPTH);
        chk(empty == (n == 0), {"R5 settled empty ", tag}, empty, n == 0);
        chk(prog_full == (n >= PF), {"R8 settled prog_full ", tag}, prog_full, n >= PF);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge wr_clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int base;
        // R10: reset values
        repeat (2) @(negedge wr_clk);
        #1;
        chk(empty == 1'b1, "R10 empty in reset", empty, 1);
        chk(full == 1'b0, "R10 full in reset", full, 0);
        chk(prog_full == 1'b0, "R10 prog_full in reset", prog_full, 0);
        @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge wr_clk);
        #1;
        chk(empty == 1'b1 && full == 1'b0 && prog_full == 1'b0, "R10 after release",
            {empty, full, prog_full}, 3'b100);

        // Fill past capacity, extra writes must be dropped (R2, R4)
        wr_prob = 100;
        repeat (DEPTH + 10) @(negedge wr_clk);
        settle();
        chk(full == 1'b1, "R4 full after overfill", full, 1);
        chk(prog_full == 1'b1, "R6 prog_full when full", prog_full, 1);
        check_exact("after fill");

        // Drain past empty (R2, R5)
        base = n_pops;
        rd_prob = 100;
        repeat (DEPTH + 10) @(negedge rd_clk);
        settle();
        chk(n_pops - base == DEPTH, "R2 reads after overfill", n_pops - base, DEPTH);
        chk(empty == 1'b1, "R5 empty after drain", empty, 1);

        // Reads on empty are ignored (R3); independent-mode latency (R9)
        rd_prob = 100;
        repeat (6) @(negedge rd_clk);
        rd_prob = 0;
        wr_todo = 1;
        wait (wr_todo == 0);
        @(posedge wr_clk);
        @(posedge rd_clk);
        @(posedge rd_clk);
        @(negedge rd_clk);
        #0.5;
        chk(empty == 1'b1, "R9 independent empty still high", empty, 1);
        settle();
        chk(empty == 1'b0, "R3 word visible after empty reads", empty, 0);
        if (model_q.size() == 1)
            chk(rd_data == model_q[0], "R3 next written is next read", rd_data, model_q[0]);
        else
            chk(1'b0, "R3 model count", model_q.size(), 1);
        rd_todo = 1;
        settle();

        // Threshold boundary (R7, R8)
        wr_todo = PF - 1;
        settle();
        chk(prog_full == 1'b0, "R8 below level", prog_full, 0);
        wr_todo = 1;
        wait (wr_todo == 0);
        @(negedge wr_clk);
        #1;
        chk(prog_full == 1'b1, "R7 rise at reaching write", prog_full, 1);
        rd_todo = 1;
        wait (rd_todo == 0);
        @(posedge rd_clk);
        #1;
        chk(prog_full == 1'b1, "R8 held during crossing", prog_full, 1);
        settle();
        chk(prog_full == 1'b0, "R8 dropped after crossing", prog_full, 0);
        check_exact("at level minus one");

        // Random traffic at several densities
        for (int ph = 0; ph < 5; ph++) begin
            case (ph)
                0: begin wr_prob = 70; rd_prob = 30; end
                1: begin wr_prob = 30; rd_prob = 70; end
                2: begin wr_prob = 50; rd_prob = 50; end
                3: begin wr_prob = 95; rd_prob = 90; end
                default: begin wr_prob = 85; rd_prob = 55; end
            endcase
            repeat (1500) @(negedge wr_clk);
            settle();
            check_exact("random phase");
        end

        rd_prob = 100;
        repeat (DEPTH + 10) @(negedge rd_clk);
        settle();
        check_exact("final drain");

        // Shared-clock instance latency (R9)
        @(negedge wr_clk);
        c_wr_data = 9'h15A;
        c_wr_en = 1'b1;
        @(negedge wr_clk);
        c_wr_en = 1'b0;
        chk(c_empty == 1'b1, "R9 shared empty one edge after write", c_empty, 1);
        @(negedge wr_clk);
        chk(c_empty == 1'b0, "R9 shared empty clear at second edge", c_empty, 0);
        chk(c_rd_data == 9'h15A, "R9 shared head word", c_rd_data, 9'h15A);
        c_rd_en = 1'b1;
        @(negedge wr_clk);
        c_rd_en = 1'b0;
        @(negedge wr_clk);
        chk(c_empty == 1'b1, "R9 shared empty after read", c_empty, 1);
        chk(c_full == 1'b0 && c_pf == 1'b0, "R9 shared flags idle", {c_full, c_pf}, 0);

        finish_up();
    end

endmodule